// File: doc/BRIEF.md
# Acquisition Scan Timing Sequencer

This block produces the timing strobes for a multi-channel sampling run from one base clock. A scan-interval down-counter marks the beginning of each scan. Inside a scan, a sample-interval down-counter spaces the conversion strobes. Each conversion strobe also tells the channel-setting store to step to its next entry. A scan ends on one of two conditions, chosen by `stop_sel`: the end-of-list flag of the current entry, or a per-scan conversion counter reaching zero. A scan-count counter can end the whole run after a programmed number of scans.

Any of the three strobes (scan begin, conversion, scan end) can be taken from an external input instead of its internal counter. The controller issues a one-cycle `arm` pulse to begin a run and a `disarm` pulse to abandon it. A load value of N on any counter gives a period of N+1 base clocks, so a load value of 0 gives one strobe on every clock.

Top module: `acq_sequencer`

## Requirements
- R1: While waiting between scans, an internal scan-begin strobe (`start_o`) occurs every `scan_ival`+1 clocks, counted from the first cycle after arming. A scan-begin event that arrives while a scan is active is dropped and gives no `start_o`.
- R2: Inside a scan, `convert_o` pulses every `samp_ival`+1 clocks. The first pulse comes `samp_ival`+1 clocks after the `start_o` cycle.
- R3: With `stop_sel`=1, `stop_o` is asserted in the same cycle as conversion number `conv_per_scan`+1 of the scan.
- R4: With `stop_sel`=0, `stop_o` is asserted in the first conversion cycle in which `last_chan` is 1.
- R5: After `stop_o`, `active_o` is 0 and no `convert_o` occurs until the next `start_o`.
- R6: With `stop_on_count`=1, the run ends after `scan_count`+1 scans. `running_o` then falls and `done_o` rises in the cycle after the final `stop_o`, and `done_o` stays at 1 until the next `arm` or `disarm`. With `stop_on_count`=0, scans continue without limit.
- R7: When `ext_start_en`, `ext_conv_en` or `ext_stop_en` is 1, the matching strobe comes from `ext_start`, `ext_conv` or `ext_stop` in place of the internal source, with the same gating by scan state. An external stop does not need a conversion in the same cycle.
- R8: `arm` starts a run only when the sequencer is idle; while a run is in progress it has no effect. `disarm` returns the sequencer to idle in the next cycle and clears `done_o`, and it wins over `arm`. A run armed after a disarm starts with every counter at its programmed value.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Begin a run (honoured when idle) |
| disarm | input | 1 | Abort and return to idle |
| scan_ival | input | 24 | Scan period minus one, in clocks |
| samp_ival | input | 16 | Conversion period minus one, in clocks |
| conv_per_scan | input | 16 | Conversions per scan minus one |
| scan_count | input | 24 | Scans per run minus one |
| stop_on_count | input | 1 | End the run when the scan counter expires |
| stop_sel | input | 1 | 1: conversion counter ends a scan, 0: end-of-list flag |
| last_chan | input | 1 | End-of-list flag of the current entry |
| ext_start_en | input | 1 | Take the scan-begin strobe from `ext_start` |
| ext_start | input | 1 | External scan-begin strobe |
| ext_conv_en | input | 1 | Take the conversion strobe from `ext_conv` |
| ext_conv | input | 1 | External conversion strobe |
| ext_stop_en | input | 1 | Take the scan-end strobe from `ext_stop` |
| ext_stop | input | 1 | External scan-end strobe |
| start_o | output | 1 | Accepted scan-begin strobe |
| convert_o | output | 1 | Conversion strobe, also steps to the next entry |
| stop_o | output | 1 | Scan-end strobe |
| active_o | output | 1 | A scan is in progress |
| running_o | output | 1 | A run is armed and not finished |
| done_o | output | 1 | The run ended by scan count |

## Verification
The assertions assume three things about the inputs. The programmed values and select bits stay constant during a run. Every input is synchronous to the base clock. `arm` and `disarm` are single-cycle requests. The bench changes counter values and mode bits only while the sequencer is idle, and it drives every input one fixed delay after the rising edge. External strobes and the end-of-list flag may change on any cycle, because the sequencer is meant to accept them at any rate, including one strobe per clock.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SCAN = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       done;
    } seq_ctl_t;

endpackage

// File: rtl/seq_downcnt.sv
module seq_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         en_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         tc_o
);

    logic [W-1:0] cnt_d, cnt_q;

    assign tc_o  = (cnt_q == '0);
    assign cnt_o = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = reload_i;
        end else if (en_i) begin
            cnt_d = tc_o ? reload_i : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tc_o && !load_i) |=> (cnt_o == $past(reload_i))); // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tc_o && !load_i) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R1

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_seq_pkg::*;
#(
    parameter int SCAN_W = 24,
    parameter int SAMP_W = 16,
    parameter int CPS_W  = 16,
    parameter int NSC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm,
    input  logic [SCAN_W-1:0] scan_ival,
    input  logic [SAMP_W-1:0] samp_ival,
    input  logic [CPS_W-1:0]  conv_per_scan,
    input  logic [NSC_W-1:0]  scan_count,
    input  logic              stop_on_count,
    input  logic              stop_sel,
    input  logic              last_chan,
    input  logic              ext_start_en,
    input  logic              ext_start,
    input  logic              ext_conv_en,
    input  logic              ext_conv,
    input  logic              ext_stop_en,
    input  logic              ext_stop,
    output logic              start_o,
    output logic              convert_o,
    output logic              stop_o,
    output logic              active_o,
    output logic              running_o,
    output logic              done_o
);

    seq_ctl_t ctl_d, ctl_q;

    logic              in_idle, in_wait, in_scan;
    logic              si_tc, ss_tc, cps_tc, nsc_tc;
    logic [SCAN_W-1:0] si_cnt;
    logic [SAMP_W-1:0] ss_cnt;
    logic [CPS_W-1:0]  cps_cnt;
    logic [NSC_W-1:0]  nsc_cnt;
    logic              raw_start, raw_conv, int_stop;

    assign in_idle = (ctl_q.state == ST_IDLE);
    assign in_wait = (ctl_q.state == ST_WAIT);
    assign in_scan = (ctl_q.state == ST_SCAN);

    // Scan-interval counter: free-runs whenever a run is armed.
    seq_downcnt #(.W(SCAN_W)) u_scan_ival (
        .clk(clk), .rst_n(rst_n),
        .load_i(in_idle), .en_i(1'b1), .reload_i(scan_ival),
        .cnt_o(si_cnt), .tc_o(si_tc)
    );

    // Sample-interval counter: held at its load value outside a scan.
    seq_downcnt #(.W(SAMP_W)) u_samp_ival (
        .clk(clk), .rst_n(rst_n),
        .load_i(!in_scan), .en_i(1'b1), .reload_i(samp_ival),
        .cnt_o(ss_cnt), .tc_o(ss_tc)
    );

    // Conversions-per-scan counter: steps on every conversion.
    seq_downcnt #(.W(CPS_W)) u_conv_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_i(!in_scan), .en_i(convert_o), .reload_i(conv_per_scan),
        .cnt_o(cps_cnt), .tc_o(cps_tc)
    );

    // Scan counter: steps on every scan end.
    seq_downcnt #(.W(NSC_W)) u_scan_cnt (
        .clk(clk), .rst_n(rst_n),
        .load_i(in_idle), .en_i(stop_o), .reload_i(scan_count),
        .cnt_o(nsc_cnt), .tc_o(nsc_tc)
    );

    // Source selection and gating by scan state.
    assign raw_start = ext_start_en ? ext_start : si_tc;
    assign raw_conv  = ext_conv_en  ? ext_conv  : ss_tc;
    assign start_o   = in_wait && raw_start;
    assign convert_o = in_scan && raw_conv;
    assign int_stop  = convert_o && (stop_sel ? cps_tc : last_chan);
    assign stop_o    = in_scan && (ext_stop_en ? ext_stop : int_stop);

    assign active_o  = in_scan;
    assign running_o = !in_idle;
    assign done_o    = ctl_q.done;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (arm) begin
                    ctl_d.state = ST_WAIT;
                    ctl_d.done  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (start_o) ctl_d.state = ST_SCAN;
            end
            ST_SCAN: begin
                if (stop_o) begin
                    if (stop_on_count && nsc_tc) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = ST_WAIT;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (disarm) begin
            ctl_d.state = ST_IDLE;
            ctl_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_START_OPENS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !disarm) |=> active_o); // R1

    AST_STOP_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && !ext_stop_en) |-> convert_o); // R3

    AST_NO_CONV_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> (!convert_o && !active_o)); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !running_o); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm && !disarm) |=> done_o); // R6

    AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (!running_o && !done_o)); // R8

endmodule

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, disarm = 1'b0;
    logic [23:0] scan_ival = 24'd20;
    logic [15:0] samp_ival = 16'd3;
    logic [15:0] conv_per_scan = 16'd2;
    logic [23:0] scan_count = 24'd2;
    logic        stop_on_count = 1'b1, stop_sel = 1'b1, last_chan = 1'b0;
    logic        ext_start_en = 1'b0, ext_start = 1'b0;
    logic        ext_conv_en = 1'b0, ext_conv = 1'b0;
    logic        ext_stop_en = 1'b0, ext_stop = 1'b0;
    logic        start_o, convert_o, stop_o, active_o, running_o, done_o;

    int  checks = 0, errors = 0;
    bit  rnd_flag = 0, rnd_ext = 0, finished = 0;

    always #2 clk = ~clk;

    acq_sequencer uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
        .scan_ival(scan_ival), .samp_ival(samp_ival),
        .conv_per_scan(conv_per_scan), .scan_count(scan_count),
        .stop_on_count(stop_on_count), .stop_sel(stop_sel), .last_chan(last_chan),
        .ext_start_en(ext_start_en), .ext_start(ext_start),
        .ext_conv_en(ext_conv_en), .ext_conv(ext_conv),
        .ext_stop_en(ext_stop_en), .ext_stop(ext_stop),
        .start_o(start_o), .convert_o(convert_o), .stop_o(stop_o),
        .active_o(active_o), .running_o(running_o), .done_o(done_o)
    );

    // Behavioural reference: mode 0 idle, 1 between scans, 2 in scan.
    int  m_mode = 0;
    int  m_si = 0, m_ss = 0, m_cps = 0, m_nsc = 0;
    bit  m_done = 0;
    bit  e_start, e_conv, e_stop;

    function automatic void model_outputs();
        bit rs, rc;
        rs = ext_start_en ? ext_start : (m_si == 0);
        rc = ext_conv_en ? ext_conv : (m_ss == 0);
        e_start = (m_mode == 1) && rs;
        e_conv  = (m_mode == 2) && rc;
        e_stop  = (m_mode == 2) &&
                  (ext_stop_en ? ext_stop : (e_conv && (stop_sel ? (m_cps == 0) : last_chan)));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_done = 0; m_si = 0; m_ss = 0; m_cps = 0; m_nsc = 0;
        end else begin
            int old;
            model_outputs();
            old = m_mode;
            if (old == 0) m_si = scan_ival;
            else m_si = (m_si == 0) ? int'(scan_ival) : m_si - 1;
            if (old != 2) m_ss = samp_ival;
            else m_ss = (m_ss == 0) ? int'(samp_ival) : m_ss - 1;
            if (old != 2) m_cps = conv_per_scan;
            else if (e_conv) m_cps = (m_cps == 0) ? int'(conv_per_scan) : m_cps - 1;
            if (old == 0) m_nsc = scan_count;
            else if (e_stop) m_nsc = (m_nsc == 0) ? int'(scan_count) : m_nsc - 1;
            if (old == 0 && arm) begin m_mode = 1; m_done = 0; end
            else if (old == 1 && e_start) m_mode = 2;
            else if (old == 2 && e_stop) begin
                if (stop_on_count && m_nsc == int'(scan_count) && e_stop &&
                    (old == 2)) begin
                    // scan counter was at zero before this stop (it just reloaded)
                end
            end
            if (old == 2 && e_stop) begin
                if (stop_on_count && last_nsc_zero) begin m_mode = 0; m_done = 1; end
                else m_mode = 1;
            end
            if (disarm) begin m_mode = 0; m_done = 0; end
        end
    end

    // Scan counter zero flag sampled before the edge update.
    bit last_nsc_zero;
    always @(negedge clk) last_nsc_zero = (m_nsc == 0);

    task automatic check_bit(string req, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s got %0b expected %0b at %0t", req, name, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            model_outputs();
            check_bit("R1", "start_o", start_o, e_start);
            check_bit(stop_sel ? "R3" : "R4", "stop_o", stop_o, e_stop);
            check_bit("R2", "convert_o", convert_o, e_conv);
            check_bit("R5", "active_o", active_o, m_mode == 2);
            check_bit("R8", "running_o", running_o, m_mode != 0);
            check_bit("R6", "done_o", done_o, m_done);
            if (ext_start_en || ext_conv_en || ext_stop_en)
                check_bit("R7", "ext convert_o", convert_o, e_conv);
        end
    end

    // Random end-of-list flag and external strobes.
    always @(posedge clk) begin
        #1;
        last_chan = rnd_flag ? ($urandom_range(0, 2) == 0) : 1'b0;
        if (rnd_ext) begin
            ext_start = ($urandom_range(0, 5) == 0);
            ext_conv  = ($urandom_range(0, 2) == 0);
            ext_stop  = ($urandom_range(0, 6) == 0);
        end else begin
            ext_start = 1'b0; ext_conv = 1'b0; ext_stop = 1'b0;
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic pulse_arm();
        arm = 1'b1; cycles(1); arm = 1'b0;
    endtask

    task automatic pulse_disarm();
        disarm = 1'b1; cycles(1); disarm = 1'b0;
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit && !done_o; i++) cycles(1);
    endtask

    task automatic summary();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1;
        @(negedge clk);
        check_bit("R9", "reset start_o", start_o, 1'b0);
        check_bit("R9", "reset running_o", running_o, 1'b0);
        check_bit("R9", "reset done_o", done_o, 1'b0);
        cycles(2);
        rst_n = 1'b1;
        cycles(2);

        // Count-terminated scans, run ends after three scans (R3, R6).
        pulse_arm();
        wait_done(400);
        check_bit("R6", "done after count", done_o, 1'b1);
        cycles(5);
        check_bit("R6", "done held", done_o, 1'b1);

        // End-of-list flag terminates scans (R4).
        stop_sel = 1'b0; rnd_flag = 1; scan_count = 24'd4;
        pulse_arm();
        check_bit("R6", "arm clears done", done_o, 1'b0);
        wait_done(2000);
        rnd_flag = 0;

        // Short scan period: begin events inside a scan are dropped (R1, R5).
        stop_sel = 1'b1; scan_ival = 24'd5; samp_ival = 16'd4; conv_per_scan = 16'd3;
        pulse_arm();
        cycles(10);
        pulse_arm();   // ignored while running (R8)
        wait_done(2000);

        // Minimum values: a strobe on every clock (R2).
        scan_ival = 24'd0; samp_ival = 16'd0; conv_per_scan = 16'd0; scan_count = 24'd7;
        pulse_arm();
        wait_done(200);

        // External sources (R7).
        scan_ival = 24'd9; samp_ival = 16'd2; conv_per_scan = 16'd5;
        ext_start_en = 1'b1; ext_conv_en = 1'b1; ext_stop_en = 1'b1; rnd_ext = 1;
        pulse_arm();
        wait_done(3000);
        ext_stop_en = 1'b0; stop_sel = 1'b1;
        pulse_arm();
        wait_done(3000);
        rnd_ext = 0; ext_start_en = 1'b0; ext_conv_en = 1'b0;

        // Free-running run stopped by disarm mid-scan (R6, R8).
        stop_on_count = 1'b0; scan_ival = 24'd12; samp_ival = 16'd1; conv_per_scan = 16'd2;
        pulse_arm();
        cycles(300);
        check_bit("R6", "no end without count", running_o, 1'b1);
        for (int i = 0; i < 40 && !active_o; i++) cycles(1);
        pulse_disarm();
        check_bit("R8", "disarm idle", running_o, 1'b0);
        arm = 1'b1; disarm = 1'b1; cycles(1); arm = 1'b0; disarm = 1'b0;
        check_bit("R8", "disarm wins", running_o, 1'b0);
        pulse_arm();
        cycles(100);
        pulse_disarm();
        cycles(3);
        summary();
    end

    initial begin
        #(4 * 190000);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

endmodule